// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block connects a processor's register bus to three 8-bit parallel ports, named A, B and C. Port C is handled as two independent 4-bit halves, upper (bits 7:4) and lower (bits 3:0). The processor drives a chip select, read and write strobes, a 2-bit register address and an 8-bit data bus. The data bus leaves the block as a data-out vector with a separate output-enable, not as a tri-state pin. Each port pin has its own output value, output enable and input value.

A single control byte does one of two things. With its top bit set, it programs the direction and mode of both port groups: group A is port A plus C upper, and group B is port B plus C lower. With its top bit clear, it sets or clears one bit of port C. The block only carries out basic input/output. The two group mode fields are stored and read back, but they do not change port behaviour.

Writes go through a small state machine clocked on the system clock. The active write strobe (chip select low and write low) is synchronised over `SYNC_STAGES` flops. The machine has three states:
- **W_IDLE** moves to **W_COMMIT** when the synchronised strobe is seen.
- **W_COMMIT** lasts exactly one cycle. In it the address and data are captured and the target register is updated. It then moves to **W_HOLD**.
- **W_HOLD** waits and returns to **W_IDLE** once the synchronised strobe has gone away.

Reads are combinational from the address and the live pins.

Top module: `ppi_core`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register, for both reads and writes. Writing a port address loads that port's output latch, which drives its `*_out` pins.
- R2: `data_oe` is 1 only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. At all other times it is 0 and `data_out` is 0.
- R3: After reset, the control register reads 0x9B, every port output enable is 0 and every output latch is 0.
- R4: In a mode-set byte, bit 4 sets the port A direction, bit 3 sets C upper, bit 1 sets port B and bit 0 sets C lower. A value of 1 means input (enables all 0) and 0 means output (enables all 1).
- R5: The group A mode field (bits 6:5) and the group B mode bit (bit 2) of a mode-set byte are stored and read back unchanged.
- R6: A control byte with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3:1. Bits 6:4 are ignored, and the stored mode word is not changed.
- R7: Every mode-set write clears the A, B and C output latches to 0.
- R8: A read of the control address returns the stored mode word in bits 6:0, with bit 7 always 1.
- R9: Each low pulse of the write strobe updates a register once, with the data captured shortly after the strobe falls. Data changes later in the same pulse are ignored.
- R10: A port read returns the live input pins for a port set to input, and its output latch for a port set to output. Port C chooses this separately for each half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin drive enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pin drive enables |

## Verification
The assertions check on every cycle that:
- the bus enable stays off unless a read is under way, and a control read always carries bit 7 set;
- the commit pulse never lasts two cycles;
- a bit set/reset byte leaves the mode word untouched;
- a mode-set byte empties all three latches;
- each port drives its pins as a single group.

Other behaviour needs the bench's scenarios:
- the value loaded at reset;
- all sixteen direction combinations, checked against both the live pins and the latches;
- the bit-index decoding of set/reset;
- data changing in the middle of a held write strobe.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int DW = 8;
    localparam int BW = $clog2(DW);

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } sel_e;

    // field order matches control byte bits 6..0
    typedef struct packed {
        logic [1:0] ga_mode;
        logic       a_in;
        logic       cu_in;
        logic       gb_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = 7'h1B;

    typedef enum logic [1:0] {
        W_IDLE,
        W_COMMIT,
        W_HOLD
    } wst_e;
endpackage

// File: rtl/ppi_wr_fsm.sv
module ppi_wr_fsm
    import ppi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   act_s;
    wst_e                   state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ~cs_n & ~wr_n};
    end
    assign act_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) state_q <= W_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:   if (act_s) state_d = W_COMMIT;
            W_COMMIT: state_d = W_HOLD;
            W_HOLD:   if (!act_s) state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = (state_q == W_COMMIT);
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pulse,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic [DW-1:0] a_lat,
    output logic [DW-1:0] b_lat,
    output logic [DW-1:0] c_lat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            a_lat <= '0;
            b_lat <= '0;
            c_lat <= '0;
        end else if (wr_pulse) begin
            unique case (sel_e'(sel))
                SEL_A: a_lat <= wdata;
                SEL_B: b_lat <= wdata;
                SEL_C: c_lat <= wdata;
                SEL_CTL: begin
                    if (wdata[DW-1]) begin
                        cfg   <= cfg_t'(wdata[DW-2:0]);
                        a_lat <= '0;
                        b_lat <= '0;
                        c_lat <= '0;
                    end else begin
                        c_lat[wdata[BW:1]] <= wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    p_bsr_keeps_cfg_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && sel == 2'b11 && !wdata[DW-1]) |=> $stable(cfg));
    p_modeset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && sel == 2'b11 && wdata[DW-1]) |=>
        (a_lat == '0 && b_lat == '0 && c_lat == '0));
endmodule

// File: rtl/ppi_rdmux.sv
module ppi_rdmux
    import ppi_pkg::*;
(
    input  logic [1:0]    sel,
    input  cfg_t          cfg,
    input  logic [DW-1:0] a_lat,
    input  logic [DW-1:0] b_lat,
    input  logic [DW-1:0] c_lat,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] rdata
);
    localparam int HW = DW / 2;
    logic [HW-1:0] c_hi, c_lo;

    assign c_hi = cfg.cu_in ? pc_in[DW-1:HW] : c_lat[DW-1:HW];
    assign c_lo = cfg.cl_in ? pc_in[HW-1:0]  : c_lat[HW-1:0];

    always_comb begin
        unique case (sel_e'(sel))
            SEL_A:   rdata = cfg.a_in ? pa_in : a_lat;
            SEL_B:   rdata = cfg.b_in ? pb_in : b_lat;
            SEL_C:   rdata = {c_hi, c_lo};
            SEL_CTL: rdata = {1'b1, cfg};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
    import ppi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    localparam int HW = DW / 2;

    logic          wr_pulse;
    cfg_t          cfg;
    logic [DW-1:0] a_lat, b_lat, c_lat, rdata;

    ppi_wr_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .wr_pulse(wr_pulse)
    );

    ppi_regs u_regs (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .sel(addr), .wdata(data_in),
        .cfg(cfg), .a_lat(a_lat), .b_lat(b_lat), .c_lat(c_lat)
    );

    ppi_rdmux u_rd (
        .sel(addr), .cfg(cfg), .a_lat(a_lat), .b_lat(b_lat), .c_lat(c_lat),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .rdata(rdata)
    );

    assign data_oe  = ~cs_n & ~rd_n & wr_n;
    assign data_out = data_oe ? rdata : '0;

    assign pa_out = a_lat;
    assign pb_out = b_lat;
    assign pc_out = c_lat;
    assign pa_oe  = {DW{~cfg.a_in}};
    assign pb_oe  = {DW{~cfg.b_in}};
    assign pc_oe  = {{HW{~cfg.cu_in}}, {HW{~cfg.cl_in}}};

    p_oe_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!data_oe && data_out == '0));
    p_ctl_msb_r8: assert property (@(posedge clk) disable iff (rst)
        (data_oe && addr == 2'b11) |-> data_out[DW-1]);
    p_group_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1));
endmodule

// File: tb/tb_ppi_core.sv
`timescale 1ns/1ps
module tb_ppi_core;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] data_in = '0, pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] data_out, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       data_oe;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [6:0] m_cfg;
    logic [7:0] m_a, m_b, m_c;

    always #2.5 clk = ~clk;

    ppi_core dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d; cs_n = 0; wr_n = 0;
        repeat (6) @(negedge clk);
        wr_n = 1; cs_n = 1;
        repeat (3) @(negedge clk);
        if (a == 2'd0) m_a = d;
        else if (a == 2'd1) m_b = d;
        else if (a == 2'd2) m_c = d;
        else if (d[7]) begin m_cfg = d[6:0]; m_a = 0; m_b = 0; m_c = 0; end
        else m_c[d[3:1]] = d[0];
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
        #1; d = data_out; oe = data_oe;
        @(negedge clk); rd_n = 1; cs_n = 1;
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cfg[4] ? pa_in : m_a;
            2'd1: return m_cfg[1] ? pb_in : m_b;
            2'd2: return {m_cfg[3] ? pc_in[7:4] : m_c[7:4], m_cfg[0] ? pc_in[3:0] : m_c[3:0]};
            default: return {1'b1, m_cfg};
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic oe;
        m_cfg = 7'h1B; m_a = 0; m_b = 0; m_c = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R3 reset state
        chk("R3 pa_oe", pa_oe, 8'h00);
        chk("R3 pb_oe", pb_oe, 8'h00);
        chk("R3 pc_oe", pc_oe, 8'h00);
        chk("R3 latches", pa_out | pb_out | pc_out, 8'h00);
        chk("R2 idle oe", {7'd0, data_oe}, 8'h00);
        bus_read(2'd3, rd, oe);
        chk("R3 control 9B", rd, 8'h9B);
        chk("R2 read oe", {7'd0, oe}, 8'h01);

        // sweep all 16 direction combinations
        for (int k = 0; k < 16; k++) begin
            logic [7:0] cw;
            cw = {1'b1, k[1:0], k[3], k[2], k[0], k[1], k[0]};
            cw[4] = k[3]; cw[3] = k[2]; cw[1] = k[1]; cw[0] = k[0];
            cw[6:5] = k[1:0] ^ k[3:2]; cw[2] = k[2] ^ k[0];
            bus_write(2'd0, 8'hA5);
            bus_write(2'd1, 8'h5A);
            bus_write(2'd2, 8'h3C);
            bus_write(2'd3, cw);
            // R7 latches cleared
            chk("R7 pa_out cleared", pa_out, 8'h00);
            chk("R7 pb_out cleared", pb_out, 8'h00);
            chk("R7 pc_out cleared", pc_out, 8'h00);
            // R4 directions
            chk("R4 pa_oe", pa_oe, cw[4] ? 8'h00 : 8'hFF);
            chk("R4 pb_oe", pb_oe, cw[1] ? 8'h00 : 8'hFF);
            chk("R4 pc_oe", pc_oe, {cw[3] ? 4'h0 : 4'hF, cw[0] ? 4'h0 : 4'hF});
            // R5 / R8 readback
            bus_read(2'd3, rd, oe);
            chk("R5 R8 control readback", rd, cw);
            // R1 / R10 data paths
            bus_write(2'd0, 8'(k * 17) ^ 8'h96);
            bus_write(2'd1, 8'(k * 29) ^ 8'h3B);
            bus_write(2'd2, 8'(k * 13) ^ 8'hC7);
            chk("R1 pa_out", pa_out, m_a);
            chk("R1 pb_out", pb_out, m_b);
            chk("R1 pc_out", pc_out, m_c);
            pa_in = 8'(k * 7) ^ 8'h5E;
            pb_in = ~8'(k * 11);
            pc_in = 8'(k * 37) ^ 8'h81;
            for (int a = 0; a < 3; a++) begin
                bus_read(2'(a), rd, oe);
                chk("R10 R1 port read", rd, exp_read(2'(a)));
            end
        end

        // R6 bit set/reset sweep, all outputs, junk in bits 6:4
        bus_write(2'd3, 8'h80);
        for (int i = 0; i < 8; i++) begin
            bus_write(2'd3, {1'b0, 3'(i), 3'(i), 1'b1});
            chk("R6 bit set", pc_out, m_c);
        end
        chk("R6 all set", pc_out, 8'hFF);
        for (int i = 0; i < 8; i += 2) begin
            bus_write(2'd3, {1'b0, 3'(7 - i), 3'(i), 1'b0});
            chk("R6 bit reset", pc_out, m_c);
        end
        chk("R6 even cleared", pc_out, 8'hAA);
        bus_read(2'd3, rd, oe);
        chk("R6 mode word kept", rd, 8'h80);
        chk("R6 other latches", pa_out | pb_out, 8'h00);

        // R9 data change during a held strobe is ignored
        @(negedge clk); addr = 2'd0; data_in = 8'h11; cs_n = 0; wr_n = 0;
        repeat (6) @(negedge clk);
        data_in = 8'h22;
        repeat (6) @(negedge clk);
        wr_n = 1; cs_n = 1;
        repeat (4) @(negedge clk);
        chk("R9 single capture", pa_out, 8'h11);

        // R2 bus enable gating
        @(negedge clk); cs_n = 1; rd_n = 0; addr = 2'd3; #1;
        chk("R2 cs high", {7'd0, data_oe}, 8'h00);
        chk("R2 cs high data", data_out, 8'h00);
        @(negedge clk); cs_n = 0; rd_n = 1; #1;
        chk("R2 no strobe", {7'd0, data_oe}, 8'h00);
        @(negedge clk); rd_n = 0; wr_n = 0; #1;
        chk("R2 rd and wr low", {7'd0, data_oe}, 8'h00);
        @(negedge clk); rd_n = 1; wr_n = 1; cs_n = 1;
        repeat (6) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule